// File: doc/BRIEF.md
# I/O Address Descriptor Router

This block decides where an I/O request goes. It holds a small bank of 64-bit descriptors. Each descriptor has a destination port, a selector for the special-cycle flag, a 20-bit base and a 20-bit mask. A register port with an index reads and writes the descriptors. Every accepted request brings a 32-bit physical address and a special-cycle flag. A high flag marks a non-ordinary transaction, such as a halt or shutdown cycle.

The block compares the request against all descriptors in parallel. Address bits [31:12] are ANDed with each mask and compared to that descriptor's base. The descriptor's selector must also agree with the request's flag. When several descriptors hit, the lowest index wins and a multi-hit flag is raised. A request that hits nothing goes to a default port that software programs, and a miss flag is raised. The result is registered and appears one cycle after the request is accepted.

A two-state machine drives the response. In `S_IDLE` no result is presented. An accepted request moves the machine to `S_RESULT`, which presents the result for that cycle. From `S_RESULT`, another accepted request keeps the machine in `S_RESULT`; otherwise it returns to `S_IDLE`.

Top module: `iodesc_router`

## Requirements
- R1: Descriptor field layout is as follows. Bits 63:61 hold the destination port, bit 60 the flag selector, bits 39:20 the base and bits 19:0 the mask. Bits 59:40 read as zero and ignore written data.
- R2: Reset state of the registers:
  - Every descriptor resets to 0x000000FF_FFF00000.
  - The default-port register sits at index NUM_DESC (4) and holds the port in bits 2:0. It resets to 0, and its other bits read as zero.
- R3: A descriptor hits only if (addr[31:12] & mask) == base.
- R4: A descriptor with selector 0 hits only requests whose special flag is low. A descriptor with selector 1 hits only requests whose special flag is high.
- R5: A descriptor left at its reset value never hits, for any address and either flag value.
- R6: When several descriptors hit, the result takes the lowest-indexed hitting descriptor's port and rsp_multi is 1. With exactly one hit, rsp_multi is 0.
- R7: A miss gives rsp_hit=0, rsp_miss=1 and rsp_port equal to the default-port register.
- R8: Response timing:
  - req_ready is always 1.
  - rsp_valid is 1 in the cycle after each accepted request and 0 otherwise.
  - rsp_hit and rsp_miss are complements whenever rsp_valid is 1.
- R9: A register access with cfg_en high and an index above NUM_DESC sets cfg_err in that cycle and returns zero on cfg_rdata. A write at such an index changes no register.
- R10: cfg_rdata shows the addressed register combinationally while cfg_en is high. It is zero while cfg_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Register access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_idx | input | IDX_W | Register index |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data |
| cfg_err | output | 1 | Index out of range |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_addr | input | 32 | Physical I/O address |
| req_special | input | 1 | Special-cycle flag |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | A descriptor hit |
| rsp_miss | output | 1 | No descriptor hit |
| rsp_multi | output | 1 | Two or more descriptors hit |
| rsp_port | output | 3 | Destination port |

## Verification
The hardest cases to reach from the ports are simultaneous hits on several descriptors and hits that fail only because of the flag selector. Random 20-bit bases and masks almost never overlap by chance.

The stimulus therefore programs descriptors with bases taken inside their own masks. It draws addresses from a chosen descriptor's base, filling the unmasked bits at random. A directed case loads overlapping descriptors with wide masks, so that priority and the multi-hit flag are checked against a bench model.

// File: rtl/iodesc_pkg.sv
package iodesc_pkg;
    localparam int          DESC_W   = 64;
    localparam int          PORT_W   = 3;
    localparam int          FIELD_W  = 20;
    localparam logic [63:0] DESC_RST = 64'h0000_00FF_FFF0_0000;

    typedef struct packed {
        logic [PORT_W-1:0]  dest;
        logic               sel;
        logic [FIELD_W-1:0] rsvd;
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] mask;
    } desc_t;

    typedef enum logic {S_IDLE, S_RESULT} rsp_state_e;
endpackage

// File: rtl/iodesc_regs.sv
module iodesc_regs
    import iodesc_pkg::*;
#(
    parameter int NUM_DESC = 4,
    parameter int IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [63:0]       cfg_wdata,
    output logic [63:0]       cfg_rdata,
    output logic              cfg_err,
    output desc_t             desc_o [NUM_DESC],
    output logic [PORT_W-1:0] dflt_port_o
);
    localparam logic [IDX_W-1:0] DFLT_IDX = IDX_W'(NUM_DESC);

    desc_t             desc_q [NUM_DESC];
    logic [PORT_W-1:0] dflt_q;
    logic              wr_go;

    assign wr_go = cfg_en && cfg_wr;

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                desc_q[g] <= desc_t'(DESC_RST);
            end else if (wr_go && cfg_idx == IDX_W'(g)) begin
                desc_q[g] <= desc_t'({cfg_wdata[63:60], {FIELD_W{1'b0}}, cfg_wdata[39:0]});
            end
        end
        assign desc_o[g] = desc_q[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dflt_q <= '0;
        end else if (wr_go && cfg_idx == DFLT_IDX) begin
            dflt_q <= cfg_wdata[PORT_W-1:0];
        end
    end
    assign dflt_port_o = dflt_q;

    always_comb begin
        cfg_rdata = '0;
        cfg_err   = 1'b0;
        if (cfg_en) begin
            if (cfg_idx == DFLT_IDX) begin
                cfg_rdata = {{(64-PORT_W){1'b0}}, dflt_q};
            end else if (cfg_idx > DFLT_IDX) begin
                cfg_err = 1'b1;
            end
            for (int i = 0; i < NUM_DESC; i++) begin
                if (cfg_idx == IDX_W'(i)) cfg_rdata = desc_q[i];
            end
        end
    end
endmodule

// File: rtl/iodesc_match.sv
module iodesc_match
    import iodesc_pkg::*;
#(
    parameter int NUM_DESC = 4
) (
    input  desc_t               desc_i [NUM_DESC],
    input  logic [31:0]         addr,
    input  logic                special,
    output logic [NUM_DESC-1:0] hit
);
    logic [FIELD_W-1:0] page;
    assign page = addr[31:12];

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_cmp
        assign hit[g] = ((page & desc_i[g].mask) == desc_i[g].base)
                        && (desc_i[g].sel == special);
    end
endmodule

// File: rtl/iodesc_prio.sv
module iodesc_prio
    import iodesc_pkg::*;
#(
    parameter int NUM_DESC = 4
) (
    input  logic [NUM_DESC-1:0] hit,
    input  desc_t               desc_i [NUM_DESC],
    output logic                any_hit,
    output logic                multi,
    output logic [PORT_W-1:0]   win_port
);
    always_comb begin
        win_port = '0;
        for (int i = NUM_DESC - 1; i >= 0; i--) begin
            if (hit[i]) win_port = desc_i[i].dest;
        end
    end

    assign any_hit = |hit;
    assign multi   = $countones(hit) > 1;
endmodule

// File: rtl/iodesc_router.sv
module iodesc_router
    import iodesc_pkg::*;
#(
    parameter int NUM_DESC = 4,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_wr,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [63:0]      cfg_wdata,
    output logic [63:0]      cfg_rdata,
    output logic             cfg_err,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_addr,
    input  logic             req_special,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_multi,
    output logic [2:0]       rsp_port
);
    desc_t             desc [NUM_DESC];
    logic [PORT_W-1:0] dflt_port;
    logic [NUM_DESC-1:0] hit_vec;
    logic              any_hit, multi_hit;
    logic [PORT_W-1:0] win_port;
    logic              accept;
    rsp_state_e        state, nxt;

    iodesc_regs #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_err(cfg_err), .desc_o(desc), .dflt_port_o(dflt_port)
    );

    iodesc_match #(.NUM_DESC(NUM_DESC)) u_match (
        .desc_i(desc), .addr(req_addr), .special(req_special), .hit(hit_vec)
    );

    iodesc_prio #(.NUM_DESC(NUM_DESC)) u_prio (
        .hit(hit_vec), .desc_i(desc), .any_hit(any_hit),
        .multi(multi_hit), .win_port(win_port)
    );

    assign req_ready = 1'b1;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   nxt = accept ? S_RESULT : S_IDLE;
            S_RESULT: nxt = accept ? S_RESULT : S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_multi <= 1'b0;
            rsp_port  <= '0;
        end else if (accept) begin
            rsp_hit   <= any_hit;
            rsp_miss  <= !any_hit;
            rsp_multi <= multi_hit;
            rsp_port  <= any_hit ? win_port : dflt_port;
        end
    end

    assign rsp_valid = (state == S_RESULT);
endmodule

// File: rtl/iodesc_router_chk.sv
module iodesc_router_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_miss,
    input logic rsp_multi,
    input logic cfg_en,
    input logic cfg_err
);
    // R8
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    // R8
    no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);
    // R8
    always_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
    // R7
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));
    // R6
    multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_multi) |-> rsp_hit);
    // R9
    err_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> cfg_en);
endmodule

bind iodesc_router iodesc_router_chk u_chk (.*);

// File: tb/iodesc_router_tb.sv
module iodesc_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        cfg_err;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_addr = '0;
    logic        req_special = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_multi;
    logic [2:0]  rsp_port;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    logic [2:0]  m_dest [ND];
    logic        m_sel  [ND];
    logic [19:0] m_base [ND];
    logic [19:0] m_mask [ND];
    logic [2:0]  m_dflt;

    always #(CLK_PERIOD/2) clk = ~clk;

    iodesc_router u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_word(input int i);
        return {m_dest[i], m_sel[i], 20'h0, m_base[i], m_mask[i]};
    endfunction

    // returns {hit, multi, port}
    function automatic logic [4:0] model_route(input logic [31:0] a, input logic sp);
        int cnt = 0;
        logic [2:0] p = m_dflt;
        for (int i = ND - 1; i >= 0; i--) begin
            if (((a[31:12] & m_mask[i]) == m_base[i]) && (m_sel[i] == sp)) begin
                cnt++;
                p = m_dest[i];
            end
        end
        return {cnt > 0, cnt > 1, p};
    endfunction

    task automatic cfg_write(input logic [2:0] idx, input logic [63:0] d);
        @(negedge clk);
        cfg_en = 1; cfg_wr = 1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_en = 0; cfg_wr = 0;
        if (idx < 3'(ND)) begin
            m_dest[idx] = d[63:61]; m_sel[idx] = d[60];
            m_base[idx] = d[39:20]; m_mask[idx] = d[19:0];
        end else if (idx == 3'(ND)) begin
            m_dflt = d[2:0];
        end
    endtask

    task automatic cfg_read(input logic [2:0] idx, input string tag);
        logic [63:0] exp;
        @(negedge clk);
        cfg_en = 1; cfg_wr = 0; cfg_idx = idx;
        #1;
        if (idx < 3'(ND)) exp = model_word(int'(idx));
        else if (idx == 3'(ND)) exp = {61'h0, m_dflt};
        else exp = '0;
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
        chk(cfg_err == (idx > 3'(ND)), {tag, " err"}, 64'(cfg_err), 64'(idx > 3'(ND)));
        cfg_en = 0;
        #1;
        chk(cfg_rdata == 0, "R10 idle rdata", cfg_rdata, 0);
    endtask

    task automatic send(input logic [31:0] a, input logic sp, input string tag);
        logic [4:0] e;
        e = model_route(a, sp);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_special = sp;
        chk(req_ready == 1, "R8 ready", 64'(req_ready), 1);
        @(posedge clk); #1;
        chk(rsp_valid == 1, "R8 valid", 64'(rsp_valid), 1);
        chk({rsp_hit, rsp_multi, rsp_port} == e && rsp_miss == !e[4], tag,
            {rsp_hit, rsp_miss, rsp_multi, rsp_port}, {e[4], !e[4], e[3:0]});
        @(negedge clk);
        req_valid = 0;
        @(posedge clk); #1;
        chk(rsp_valid == 0, "R8 valid drop", 64'(rsp_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < ND; i++) begin
            m_dest[i] = 0; m_sel[i] = 0; m_base[i] = 20'hFFFFF; m_mask[i] = 0;
        end
        m_dflt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2 reset contents
        for (int i = 0; i <= ND; i++) cfg_read(3'(i), "R2 reset read");
        // R5 unprogrammed descriptors never hit
        send(32'hFFFF_F000, 1'b0, "R5 reset miss flag0");
        send(32'hFFFF_FFFF, 1'b1, "R5 reset miss flag1");
        send(32'h0000_0000, 1'b0, "R5 reset miss zero");

        // R1 reserved bits dropped
        cfg_write(0, 64'hBFFF_FFFF_F123_4FFF);
        cfg_read(0, "R1 layout rsvd");
        // R7 default port
        cfg_write(3'(ND), 64'hFFFF_FFFF_FFFF_FFF5);
        cfg_read(3'(ND), "R2 R7 dflt read");
        send(32'h0000_1000, 1'b0, "R7 miss dflt");
        // R3 / R4
        cfg_write(0, {3'd3, 1'b0, 20'h0, 20'h12340, 20'hFFFF0});
        send(32'h1234_5678, 1'b0, "R3 hit");
        send(32'h1235_5678, 1'b0, "R3 miss");
        send(32'h1234_5678, 1'b1, "R4 flag mismatch");
        cfg_write(1, {3'd6, 1'b1, 20'h0, 20'h12340, 20'hFFFF0});
        send(32'h1234_F000, 1'b1, "R4 sel1 hit");
        // R6 overlap
        cfg_write(2, {3'd2, 1'b0, 20'h0, 20'h00000, 20'h00000});
        send(32'h1234_0000, 1'b0, "R6 multi low wins");
        send(32'h7777_0000, 1'b0, "R6 single hit");
        // R9 out of range
        cfg_write(3'(ND + 2), 64'hFFFF_FFFF_FFFF_FFFF);
        cfg_read(3'(ND + 2), "R9 oor read");
        cfg_read(3'(ND + 1), "R9 oor read2");
        for (int i = 0; i <= ND; i++) cfg_read(3'(i), "R9 no side effect");

        // random phase
        for (int it = 0; it < 400; it++) begin
            if (it % 16 == 0) begin
                logic [19:0] mk;
                int k;
                k = int'($urandom_range(ND - 1, 0));
                mk = 20'($urandom) | 20'hF0000;
                cfg_write(3'(k), {3'($urandom), 1'($urandom), 20'($urandom),
                                  20'($urandom) & mk, mk});
                if (it % 64 == 0) cfg_write(3'(ND), 64'($urandom));
            end
            begin
                int k;
                logic [31:0] a;
                logic sp;
                k = int'($urandom_range(ND - 1, 0));
                a = $urandom;
                if ($urandom_range(1, 0) == 1)
                    a[31:12] = m_base[k] | (20'($urandom) & ~m_mask[k]);
                sp = ($urandom_range(3, 0) != 0) ? m_sel[k] : 1'($urandom);
                send(a, sp, "R3 R4 R6 R7 random");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule